// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address for 4 KByte pages. It does this by reading two tables in memory, one after the other. A requester hands over a linear address through a valid/ready handshake. The walker then reads a page-directory entry, uses that entry to find a page table, and reads a page-table entry. It returns either the physical address or a page-fault indication that also says which of the two levels failed.

The physical base of the page directory comes from a control-register input. A paging-enable input selects the bypass path: when paging is off, the walker reads no memory and returns the linear address unchanged. Both inputs, and the linear address, are captured when the request is accepted. Memory is reached through a plain read port. The port raises a request with an address and waits for a ready strobe that comes with the data, so the memory may add any number of wait cycles.

Top module: `xlate_walker`

## Requirements
- R1: The first read goes to the directory-entry address. This is bits 31:12 of `cr_dir_base`, then linear bits 31:22 as the index, then two zero bits. The low 12 bits of `cr_dir_base` play no part.
- R2: When `paging_en` is 0 at acceptance, `rsp_valid` rises in the cycle after acceptance. The response then has `rsp_phys_addr` equal to the linear address and `rsp_fault` at 0, and no memory read is issued.
- R3: When the directory entry has bit 0 set, the second read goes to the table-entry address. This is directory-entry bits 31:12, then linear bits 21:12, then two zero bits.
- R4: When the table entry has bit 0 set, the response has `rsp_fault` at 0. `rsp_phys_addr` is table-entry bits 31:12 followed by linear bits 11:0.
- R5: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` does not change. The walk completes for any number of wait cycles.
- R6: A directory entry with bit 0 clear ends the walk with no table read. The response has `rsp_fault` at 1, `rsp_fault_level` at 0 and `rsp_phys_addr` at 0.
- R7: A table entry with bit 0 clear ends the walk. The response has `rsp_fault` at 1, `rsp_fault_level` at 1 and `rsp_phys_addr` at 0. On a successful walk `rsp_fault_level` is 0.
- R8: `req_ready` is high only while the walker is idle. A `req_valid` raised during a walk starts no read and produces no extra response.
- R9: The linear address, `paging_en` and `cr_dir_base` are sampled at acceptance. Changing them during a walk does not alter that walk's reads or result.
- R10: `rsp_valid` is high for exactly one cycle, and `req_ready` is high in the cycle after it.
- R11: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin_addr | input | 32 | Linear address to translate |
| paging_en | input | 1 | 1 selects the table walk, 0 the bypass |
| cr_dir_base | input | 32 | Physical base of the page directory |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ready | input | 1 | Read data valid; completes the read |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result valid, one-cycle pulse |
| rsp_phys_addr | output | 32 | Translated physical address, 0 on a fault |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_level | output | 1 | Failing level: 0 directory, 1 table |

## Verification
Addresses are chosen so that the directory index, the table index and the offset each take distinct values, including all-zero and all-one fields. A wrong bit slice therefore lands on an unmapped entry and shows up as a fault or a wrong address. A second directory base is used with non-zero low bits; it shows both that the base is used and that its low bits are dropped. Walks are repeated with zero, one, three and seven wait cycles, which separates a correct address hold from a premature sample of `mem_rdata`. The bench drives `mem_rdata` with a marker value whenever `mem_ready` is low, so a premature sample is visible. Entries with the present bit clear but other bits set, the bypass with a non-trivial address, and input changes injected mid-walk separate fault level, bypass latency and capture timing.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int DIR_W  = 10;
  localparam int TBL_W  = 10;
  localparam int OFF_W  = 12;
  localparam int ENT_SH = 2;
  localparam int ADDR_W = DIR_W + TBL_W + OFF_W;
  localparam int FRM_W  = ADDR_W - OFF_W;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_DIR  = 2'd1,
    WS_TBL  = 2'd2,
    WS_DONE = 2'd3
  } walk_st_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } lvl_e;

  function automatic logic [DIR_W-1:0] dir_index(input addr_t lin);
    return lin[ADDR_W-1 -: DIR_W];
  endfunction

  function automatic logic [TBL_W-1:0] tbl_index(input addr_t lin);
    return lin[OFF_W+TBL_W-1 -: TBL_W];
  endfunction

  function automatic addr_t dir_entry_addr(input addr_t base, input addr_t lin);
    return {base[ADDR_W-1:OFF_W], dir_index(lin), {ENT_SH{1'b0}}};
  endfunction

  function automatic addr_t tbl_entry_addr(input addr_t dir_ent, input addr_t lin);
    return {dir_ent[ADDR_W-1:OFF_W], tbl_index(lin), {ENT_SH{1'b0}}};
  endfunction

  function automatic addr_t phys_of(input addr_t tbl_ent, input addr_t lin);
    return {tbl_ent[ADDR_W-1:OFF_W], lin[OFF_W-1:0]};
  endfunction

  function automatic logic entry_present(input addr_t ent);
    return ent[0];
  endfunction
endpackage

// File: rtl/xlate_req_capture.sv
module xlate_req_capture
  import xlate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  addr_t lin_in,
  input  addr_t base_in,
  output addr_t lin_q,
  output addr_t base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q  <= '0;
      base_q <= '0;
    end else if (take) begin
      lin_q  <= lin_in;
      base_q <= base_in;
    end
  end

  // R9: captured request holds while no new request is taken
  p_capture_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(lin_q) && $stable(base_q));
endmodule

// File: rtl/xlate_walk_ctrl.sv
module xlate_walk_ctrl
  import xlate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  pg_in,
  input  addr_t lin_in,
  input  addr_t lin_q,
  input  addr_t base_q,
  output logic  take,
  output logic  req_ready,
  output logic  mem_req,
  output addr_t mem_addr,
  input  logic  mem_ready,
  input  addr_t mem_rdata,
  output logic  rsp_valid,
  output addr_t rsp_phys,
  output logic  rsp_fault,
  output logic  rsp_lvl
);
  walk_st_e st_q, st_d;
  addr_t    dir_ent_q;
  addr_t    phys_q;
  logic     fault_q;
  lvl_e     lvl_q;

  logic beat, dir_beat, tbl_beat, dir_absent, tbl_absent, bypass_take;

  assign req_ready   = (st_q == WS_IDLE);
  assign take        = req_valid && req_ready;
  assign bypass_take = take && !pg_in;
  assign mem_req     = (st_q == WS_DIR) || (st_q == WS_TBL);
  assign beat        = mem_req && mem_ready;
  assign dir_beat    = beat && (st_q == WS_DIR);
  assign tbl_beat    = beat && (st_q == WS_TBL);
  assign dir_absent  = dir_beat && !entry_present(mem_rdata);
  assign tbl_absent  = tbl_beat && !entry_present(mem_rdata);

  assign mem_addr = (st_q == WS_TBL) ? tbl_entry_addr(dir_ent_q, lin_q)
                                     : dir_entry_addr(base_q, lin_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE: if (take) st_d = pg_in ? WS_DIR : WS_DONE;
      WS_DIR:  if (dir_beat) st_d = dir_absent ? WS_DONE : WS_TBL;
      WS_TBL:  if (tbl_beat) st_d = WS_DONE;
      WS_DONE: st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= WS_IDLE;
      dir_ent_q <= '0;
      phys_q    <= '0;
      fault_q   <= 1'b0;
      lvl_q     <= LVL_DIR;
    end else begin
      st_q <= st_d;
      if (dir_beat) dir_ent_q <= mem_rdata;
      if (bypass_take) begin
        phys_q  <= lin_in;
        fault_q <= 1'b0;
        lvl_q   <= LVL_DIR;
      end
      if (dir_absent) begin
        phys_q  <= '0;
        fault_q <= 1'b1;
        lvl_q   <= LVL_DIR;
      end
      if (tbl_beat) begin
        phys_q  <= tbl_absent ? '0 : phys_of(mem_rdata, lin_q);
        fault_q <= tbl_absent;
        lvl_q   <= tbl_absent ? LVL_TBL : LVL_DIR;
      end
    end
  end

  assign rsp_valid = (st_q == WS_DONE);
  assign rsp_phys  = phys_q;
  assign rsp_fault = fault_q;
  assign rsp_lvl   = lvl_q;

  // R5: the read request and its address hold until ready
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));
  // R2: bypass answers next cycle without touching memory
  p_bypass_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_take |=> rsp_valid && !mem_req && !rsp_fault);
  // R6: absent directory entry faults at level 0
  p_dir_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_absent |=> rsp_valid && rsp_fault && !rsp_lvl && rsp_phys == '0);
  // R7: absent table entry faults at level 1
  p_tbl_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_absent |=> rsp_valid && rsp_fault && rsp_lvl);
  // R4: successful walk keeps the page offset
  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_beat && !tbl_absent |=> !rsp_fault &&
      rsp_phys[OFF_W-1:0] == $past(lin_q[OFF_W-1:0]));
  // R10: single-cycle response followed by idle
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  // R8: no memory traffic while ready for a request
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin_addr,
  input  logic              paging_en,
  input  logic [ADDR_W-1:0] cr_dir_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_phys_addr,
  output logic              rsp_fault,
  output logic              rsp_fault_level
);
  logic  take;
  addr_t lin_q, base_q;

  xlate_req_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .lin_in  (req_lin_addr),
    .base_in (cr_dir_base),
    .lin_q   (lin_q),
    .base_q  (base_q)
  );

  xlate_walk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pg_in     (paging_en),
    .lin_in    (req_lin_addr),
    .lin_q     (lin_q),
    .base_q    (base_q),
    .take      (take),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_phys  (rsp_phys_addr),
    .rsp_fault (rsp_fault),
    .rsp_lvl   (rsp_fault_level)
  );
endmodule

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin_addr = '0;
  logic        paging_en = 1'b0;
  logic [31:0] cr_dir_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = 32'hDEAD_BEEF;
  logic        rsp_valid;
  logic [31:0] rsp_phys_addr;
  logic        rsp_fault;
  logic        rsp_fault_level;

  always #2.5 clk = ~clk;

  xlate_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin_addr(req_lin_addr), .paging_en(paging_en), .cr_dir_base(cr_dir_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_phys_addr(rsp_phys_addr), .rsp_fault(rsp_fault),
    .rsp_fault_level(rsp_fault_level)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] memory [int unsigned];
  logic [31:0] exp_rd_q[$];
  string       exp_tag_q[$];
  logic [31:0] exp_phys;
  logic        exp_fault, exp_lvl;
  string       exp_tag;
  bit          exp_pending = 0;
  bit          rsp_seen = 0;
  int          wait_cfg = 0;
  bit          rd_pending = 0;
  int          waits_left = 0;
  logic [31:0] held_addr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memory.exists(a) ? memory[a] : 32'h0;
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // reference memory and per-cycle comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_valid) begin
          if (!exp_pending) chk(1'b0, "R8 unexpected response", 32'h1, 32'h0);
          else begin
            chk(rsp_fault == exp_fault, {exp_tag, " fault"}, {31'b0, rsp_fault}, {31'b0, exp_fault});
            chk(rsp_phys_addr == exp_phys, {exp_tag, " phys"}, rsp_phys_addr, exp_phys);
            chk(rsp_fault_level == exp_lvl, {exp_tag, " level"}, {31'b0, rsp_fault_level}, {31'b0, exp_lvl});
            chk(exp_rd_q.size() == 0, {exp_tag, " missing reads"}, exp_rd_q.size(), 0);
          end
          chk(!req_ready, "R8 ready during response", {31'b0, req_ready}, 32'h0);
          exp_pending = 0;
          rsp_seen = 1;
        end else if (exp_pending && mem_req) begin
          chk(!req_ready, "R8 ready while walking", {31'b0, req_ready}, 32'h0);
        end
        mem_ready = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
        if (mem_req) begin
          if (!rd_pending) begin
            rd_pending = 1;
            waits_left = wait_cfg;
            held_addr  = mem_addr;
            if (exp_rd_q.size() == 0) chk(1'b0, "R2/R6 unexpected read", mem_addr, 32'h0);
            else chk(mem_addr == exp_rd_q[0], exp_tag_q[0], mem_addr, exp_rd_q[0]);
          end else begin
            chk(mem_addr == held_addr, "R5 address moved", mem_addr, held_addr);
          end
          if (waits_left == 0) begin
            mem_ready  = 1'b1;
            mem_rdata  = rd(mem_addr);
            rd_pending = 0;
            if (exp_rd_q.size() != 0) begin
              void'(exp_rd_q.pop_front());
              void'(exp_tag_q.pop_front());
            end
          end else waits_left--;
        end else if (rd_pending) begin
          chk(1'b0, "R5 request dropped", 32'h0, 32'h1);
          rd_pending = 0;
        end
      end
    end
  end

  task automatic xlate(input logic [31:0] lin, input bit pg, input logic [31:0] base,
                       input int w, input bit disturb, input string tag);
    logic [31:0] pde, pte, pa, ta;
    int cyc;
    wait_cfg = w;
    exp_fault = 0; exp_lvl = 0; exp_tag = tag;
    if (!pg) exp_phys = lin;
    else begin
      pa = {base[31:12], lin[31:22], 2'b00};
      exp_rd_q.push_back(pa); exp_tag_q.push_back("R1 directory address");
      pde = rd(pa);
      if (!pde[0]) begin exp_fault = 1; exp_lvl = 0; exp_phys = 0; end
      else begin
        ta = {pde[31:12], lin[21:12], 2'b00};
        exp_rd_q.push_back(ta); exp_tag_q.push_back("R3 table address");
        pte = rd(ta);
        if (!pte[0]) begin exp_fault = 1; exp_lvl = 1; exp_phys = 0; end
        else exp_phys = {pte[31:12], lin[11:0]};
      end
    end
    while (!req_ready) step();
    req_valid = 1; req_lin_addr = lin; paging_en = pg; cr_dir_base = base;
    exp_pending = 1; rsp_seen = 0;
    cyc = 0;
    step(); cyc++;
    req_valid = 0;
    if (disturb) begin
      // R9 and R8: new inputs and a second request while the walk runs
      req_valid = 1; req_lin_addr = ~lin; paging_en = ~pg; cr_dir_base = base ^ 32'h00F0_0000;
      step(); cyc++;
      req_valid = 0;
    end
    while (!rsp_seen && cyc < 100) begin step(); cyc++; end
    chk(rsp_seen, {tag, " no response"}, {31'b0, rsp_seen}, 32'h1);
    if (!pg) chk(cyc == 1, "R2 bypass latency", cyc, 1);
    step();
    chk(req_ready && !rsp_valid, "R10 idle after pulse", {30'b0, req_ready, rsp_valid}, 32'h2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    memory[32'h0004_0004] = 32'h0010_0003;
    memory[32'h0010_0008] = 32'h0ABC_D001;
    memory[32'h0004_000C] = 32'h0020_0000;
    memory[32'h0010_0014] = 32'h0FFF_F000;
    memory[32'h0004_0FFC] = 32'h0030_0001;
    memory[32'h0030_0FFC] = 32'hFFFF_F001;
    memory[32'h0004_0000] = 32'h0050_0001;
    memory[32'h0050_0000] = 32'h1234_5001;
    memory[32'h0008_0004] = 32'h0060_0001;
    memory[32'h0060_0008] = 32'h0777_7001;
    repeat (3) step();
    chk(req_ready === 1'b1, "R11 reset ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid === 1'b0 && mem_req === 1'b0, "R11 reset idle", {30'b0, rsp_valid, mem_req}, 32'h0);
    rst_n = 1;
    step();
    chk(req_ready && !mem_req && !rsp_valid, "R11 after reset", {29'b0, req_ready, mem_req, rsp_valid}, 32'h4);

    xlate(32'h0040_2345, 1, 32'h0004_0000, 0, 0, "R4 basic walk");
    xlate(32'hDEAD_BEEF, 0, 32'h0004_0000, 0, 0, "R2 bypass");
    xlate(32'h00C0_2345, 1, 32'h0004_0000, 1, 0, "R6 directory fault");
    xlate(32'h0040_5ABC, 1, 32'h0004_0000, 2, 0, "R7 table fault");
    xlate(32'hFFFF_FFFF, 1, 32'h0004_0000, 3, 0, "R4 top indices");
    xlate(32'h0000_0FFF, 1, 32'h0004_0000, 0, 0, "R4 zero indices");
    xlate(32'h0040_2345, 1, 32'h0008_0FFF, 1, 0, "R1 base low bits ignored");
    xlate(32'h0040_2345, 1, 32'h0004_0000, 7, 0, "R5 long wait");
    xlate(32'h0040_2345, 1, 32'h0004_0000, 3, 1, "R9 inputs changed mid-walk");
    xlate(32'h00C0_0000, 1, 32'h0004_0000, 4, 1, "R8 request during fault walk");
    xlate(32'h1234_5678, 0, 32'h0004_0000, 0, 0, "R2 bypass again");
    repeat (3) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule